// File: doc/BRIEF.md
# Protected Address Translation Cache

This block translates a 32-bit virtual address into a 28-bit physical address for 4 KB pages. It holds a set of translations in a fully associative store. Every lookup compares the virtual page number and the requester's address-space tag against all stored entries in the same cycle. A hit returns the stored frame number joined to the untranslated low 12 address bits. The result also depends on the entry's read and write rights.

No hardware fills the store. A lookup that finds no entry raises a miss. A lookup that finds an entry but lacks the needed right raises a violation. In both cases privileged software handles the exception. It writes the translation in through an update port, which can also drop one translation or clear the whole store at once. Because each entry carries the tag of its address space, switching between processes needs no clear.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid, so every valid request gives a miss and `lk_paddr` = 0.
- R2: A valid request hits when a valid entry has the same virtual page (`lk_vaddr[31:12]`) and the same tag (`lk_space`) and grants the right the access needs. On a hit `lk_paddr` = {entry frame, `lk_vaddr[11:0]`}. On any non-hit it is 0.
- R3: An entry whose tag differs from `lk_space` never matches, even when its virtual page is equal.
- R4: A matching entry gives a violation, not a hit, in two cases: a read (`lk_write`=0) when its read right is 0, or a write (`lk_write`=1) when its write right is 0.
- R5: When `lk_valid`=1, exactly one of `lk_hit`, `lk_miss`, `lk_fault` is 1. When `lk_valid`=0, all three are 0. All three follow the request inputs in the same cycle.
- R6: `upd_op`=1 (load) writes {page `upd_vpn`, tag `upd_space`, frame `upd_pfn`, rights `upd_rd`/`upd_wr`} as valid into the slot given by a replacement pointer. The pointer is 0 after reset and steps by one per load, going from ENTRIES-1 back to 0. The new entry is visible from the next cycle.
- R7: `upd_op`=2 (drop) clears every valid entry whose page and tag equal `upd_vpn`/`upd_space`. All other entries keep their translations.
- R8: `flush_all`=1 clears every entry within one clock. It takes precedence over any `upd_op` in the same cycle, and it leaves the replacement pointer unchanged.
- R9: When more than one valid entry matches a request, the lowest-numbered slot supplies the frame and rights.
- R10: `upd_op`=0 and `upd_op`=3 leave the store unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_space | input | 6 | Current address-space tag |
| lk_paddr | output | 28 | Translated physical address (0 unless hit) |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching entry (software refill needed) |
| lk_fault | output | 1 | Matching entry lacks the needed right |
| upd_op | input | 2 | 0 idle, 1 load, 2 drop, 3 idle |
| upd_vpn | input | 20 | Virtual page for load or drop |
| upd_space | input | 6 | Address-space tag for load or drop |
| upd_pfn | input | 16 | Physical frame for load |
| upd_rd | input | 1 | Read right for load |
| upd_wr | input | 1 | Write right for load |
| flush_all | input | 1 | Clear every entry |

## Verification
The bench builds the block with ENTRIES = 8. With that size, eight loads fill the store, and a ninth load exposes the pointer wrap and the eviction of slot 0 in a few cycles. With all eight slots full, the bench sweeps every page against four address-space tags, both access kinds and two page offsets. The slots carry all four read/write right combinations, so each pairing of match and right is covered. A small model of the slots, built from the requirements, predicts every result. The same setup makes duplicate-match priority, drop, flush with a same-cycle load, and the idle opcodes cheap to reach.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 28;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PFN_W  = PA_W - OFS_W;
    localparam int SPACE_W = 6;
    localparam int KEY_W  = VPN_W + SPACE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_DROP  = 2'd2,
        OP_SPARE = 2'd3
    } upd_op_e;

    typedef struct packed {
        logic               valid;
        logic               rd;
        logic               wr;
        logic [SPACE_W-1:0] space;
        logic [VPN_W-1:0]   vpn;
        logic [PFN_W-1:0]   pfn;
    } slot_t;

    function automatic logic [KEY_W-1:0] key_of(input logic [SPACE_W-1:0] s,
                                                input logic [VPN_W-1:0] v);
        return {s, v};
    endfunction

    function automatic logic right_ok(input slot_t e, input logic is_write);
        return is_write ? e.wr : e.rd;
    endfunction
endpackage

// File: rtl/xlate_match.sv
module xlate_match
    import xlate_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [N-1:0]            valid_vec,
    input  logic [N-1:0][KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]        probe,
    output logic [N-1:0]            hits
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hits[i] = valid_vec[i] && (keys[i] == probe);
    end
endmodule

// File: rtl/xlate_prio.sv
module xlate_prio #(
    parameter int N     = 64,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign any = |req;

    logic [N-1:0] below_mask;
    always_comb begin
        below_mask = '0;
        for (int i = 0; i < N; i++) below_mask[i] = (i < int'(idx));
    end

    // R9: the chosen slot requests and no lower slot does
    always_comb begin
        if (any) begin
            a_r9_lowest_wins: assert (req[idx] && ((req & below_mask) == '0))
                else $error("R9: selected slot not lowest match");
        end
    end
endmodule

// File: rtl/xlate_store.sv
module xlate_store
    import xlate_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush_all,
    input  logic [1:0]          upd_op,
    input  logic [VPN_W-1:0]    upd_vpn,
    input  logic [SPACE_W-1:0]  upd_space,
    input  logic [PFN_W-1:0]    upd_pfn,
    input  logic                upd_rd,
    input  logic                upd_wr,
    input  logic [N-1:0]        drop_hits,
    output slot_t [N-1:0]       slots
);
    slot_t [N-1:0]  slots_q;
    logic [IDX_W-1:0] ptr_q;
    upd_op_e        op;

    assign op    = upd_op_e'(upd_op);
    assign slots = slots_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) slots_q[i].valid <= 1'b0;
            ptr_q <= '0;
        end else if (flush_all) begin
            for (int i = 0; i < N; i++) slots_q[i].valid <= 1'b0;
        end else begin
            case (op)
                OP_LOAD: begin
                    slots_q[ptr_q] <= '{valid: 1'b1, rd: upd_rd, wr: upd_wr,
                                        space: upd_space, vpn: upd_vpn, pfn: upd_pfn};
                    ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
                end
                OP_DROP: begin
                    for (int i = 0; i < N; i++)
                        if (drop_hits[i]) slots_q[i].valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    logic [N-1:0] valid_vec;
    for (genvar i = 0; i < N; i++) begin : g_vv
        assign valid_vec[i] = slots_q[i].valid;
    end

    // R8: a flush leaves no valid slot and keeps the pointer
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_vec == '0) && (ptr_q == $past(ptr_q)))
        else $error("R8: slots remain valid after flush");

    // R6: a load fills the pointed slot and steps the pointer
    a_r6_load_fills: assert property (@(posedge clk) disable iff (rst)
        (!flush_all && op == OP_LOAD) |=>
            valid_vec[$past(ptr_q)] &&
            (ptr_q == (($past(ptr_q) == IDX_W'(N - 1)) ? '0 : $past(ptr_q) + 1'b1)))
        else $error("R6: load did not fill slot or step pointer");

    // R7: every slot hit by a drop is invalid afterwards
    a_r7_drop_clears: assert property (@(posedge clk) disable iff (rst)
        (!flush_all && op == OP_DROP) |=> ((valid_vec & $past(drop_hits)) == '0))
        else $error("R7: dropped slot still valid");

    // R10: idle opcodes keep the store
    a_r10_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        (!flush_all && (op == OP_IDLE || op == OP_SPARE)) |=> $stable(slots_q) && $stable(ptr_q))
        else $error("R10: idle opcode changed the store");
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic               lk_write,
    input  logic [SPACE_W-1:0] lk_space,
    output logic [PA_W-1:0]    lk_paddr,
    output logic               lk_hit,
    output logic               lk_miss,
    output logic               lk_fault,
    input  logic [1:0]         upd_op,
    input  logic [VPN_W-1:0]   upd_vpn,
    input  logic [SPACE_W-1:0] upd_space,
    input  logic [PFN_W-1:0]   upd_pfn,
    input  logic               upd_rd,
    input  logic               upd_wr,
    input  logic               flush_all
);
    slot_t [ENTRIES-1:0]            slots;
    logic [ENTRIES-1:0]             valid_vec;
    logic [ENTRIES-1:0][KEY_W-1:0]  keys;
    logic [ENTRIES-1:0]             lk_hits;
    logic [ENTRIES-1:0]             drop_hits;
    logic                           any_match;
    logic [IDX_W-1:0]               sel_idx;
    slot_t                          sel;
    logic                           allowed;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_keys
        assign valid_vec[i] = slots[i].valid;
        assign keys[i]      = key_of(slots[i].space, slots[i].vpn);
    end

    xlate_store #(.N(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush_all (flush_all),
        .upd_op    (upd_op),
        .upd_vpn   (upd_vpn),
        .upd_space (upd_space),
        .upd_pfn   (upd_pfn),
        .upd_rd    (upd_rd),
        .upd_wr    (upd_wr),
        .drop_hits (drop_hits),
        .slots     (slots)
    );

    xlate_match #(.N(ENTRIES)) u_lookup_cmp (
        .valid_vec (valid_vec),
        .keys      (keys),
        .probe     (key_of(lk_space, lk_vaddr[VA_W-1:OFS_W])),
        .hits      (lk_hits)
    );

    xlate_match #(.N(ENTRIES)) u_drop_cmp (
        .valid_vec (valid_vec),
        .keys      (keys),
        .probe     (key_of(upd_space, upd_vpn)),
        .hits      (drop_hits)
    );

    xlate_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .req (lk_hits),
        .any (any_match),
        .idx (sel_idx)
    );

    assign sel     = slots[sel_idx];
    assign allowed = right_ok(sel, lk_write);

    assign lk_hit   = lk_valid && any_match && allowed;
    assign lk_fault = lk_valid && any_match && !allowed;
    assign lk_miss  = lk_valid && !any_match;
    assign lk_paddr = lk_hit ? {sel.pfn, lk_vaddr[OFS_W-1:0]} : '0;

    // R5: exactly one outcome per valid request, none otherwise
    always_comb begin
        if (!rst) begin
            a_r5_one_outcome: assert (lk_valid ? $onehot({lk_hit, lk_miss, lk_fault})
                                               : ({lk_hit, lk_miss, lk_fault} == 3'b000))
                else $error("R5: outcome flags not exclusive");
        end
    end

    // R2: offset passes through on a hit, address is zero otherwise
    always_comb begin
        if (!rst) begin
            a_r2_offset_pass: assert (lk_hit ? (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0])
                                             : (lk_paddr == '0))
                else $error("R2: physical address malformed");
        end
    end

    // R1: the cycle after reset nothing matches
    a_r1_empty_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (valid_vec == '0))
        else $error("R1: slots valid after reset");
endmodule

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
    import xlate_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst;
    logic lk_valid, lk_write, upd_rd, upd_wr, flush_all;
    logic [VA_W-1:0]    lk_vaddr;
    logic [SPACE_W-1:0] lk_space, upd_space;
    logic [PA_W-1:0]    lk_paddr;
    logic               lk_hit, lk_miss, lk_fault;
    logic [1:0]         upd_op;
    logic [VPN_W-1:0]   upd_vpn;
    logic [PFN_W-1:0]   upd_pfn;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlate_cache #(.ENTRIES(N)) uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .lk_space(lk_space), .lk_paddr(lk_paddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .upd_op(upd_op), .upd_vpn(upd_vpn), .upd_space(upd_space),
        .upd_pfn(upd_pfn), .upd_rd(upd_rd), .upd_wr(upd_wr), .flush_all(flush_all)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model of the slots, from the requirements
    bit               m_valid [N];
    bit               m_rd [N];
    bit               m_wr [N];
    logic [SPACE_W-1:0] m_space [N];
    logic [VPN_W-1:0] m_vpn [N];
    logic [PFN_W-1:0] m_pfn [N];
    int               m_ptr;

    task automatic check(input string req, input logic [PA_W+2:0] got, input logic [PA_W+2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got hit/miss/fault/pa=%h expected %h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        upd_op = 2'd0; flush_all = 1'b0; upd_vpn = '0; upd_space = '0;
        upd_pfn = '0; upd_rd = 1'b0; upd_wr = 1'b0;
    endtask

    task automatic load(input logic [VPN_W-1:0] v, input logic [SPACE_W-1:0] s,
                        input logic [PFN_W-1:0] p, input bit r, input bit w);
        @(negedge clk);
        upd_op = 2'd1; upd_vpn = v; upd_space = s; upd_pfn = p; upd_rd = r; upd_wr = w;
        @(negedge clk);
        idle_inputs();
        m_valid[m_ptr] = 1; m_rd[m_ptr] = r; m_wr[m_ptr] = w;
        m_space[m_ptr] = s; m_vpn[m_ptr] = v; m_pfn[m_ptr] = p;
        m_ptr = (m_ptr + 1) % N;
    endtask

    task automatic drop(input logic [VPN_W-1:0] v, input logic [SPACE_W-1:0] s);
        @(negedge clk);
        upd_op = 2'd2; upd_vpn = v; upd_space = s;
        @(negedge clk);
        idle_inputs();
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == v && m_space[i] == s) m_valid[i] = 0;
    endtask

    function automatic logic [PA_W+2:0] predict(input logic [VA_W-1:0] va, input bit wr,
                                                input logic [SPACE_W-1:0] s);
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && m_vpn[i] == va[VA_W-1:OFS_W] && m_space[i] == s) begin
                if (wr ? m_wr[i] : m_rd[i])
                    return {3'b100, m_pfn[i], va[OFS_W-1:0]};
                return {3'b001, {PA_W{1'b0}}};
            end
        end
        return {3'b010, {PA_W{1'b0}}};
    endfunction

    task automatic probe(input string req, input logic [VA_W-1:0] va, input bit wr,
                         input logic [SPACE_W-1:0] s);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_space = s;
        #1;
        check(req, {lk_hit, lk_miss, lk_fault, lk_paddr}, predict(va, wr, s));
        lk_valid = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lk_valid = 1'b0; lk_vaddr = '0; lk_write = 1'b0; lk_space = '0;
        idle_inputs();
        m_ptr = 0;
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: empty after reset
        probe("R1 reset miss", 32'h1234_5678, 0, 6'd0);
        probe("R1 reset miss write", 32'hFFFF_F000, 1, 6'd3);

        // R5: no request, no flags
        lk_valid = 1'b0; lk_vaddr = 32'h0; #1;
        check("R5 idle flags", {lk_hit, lk_miss, lk_fault, lk_paddr}, '0);

        // R6: fill all slots; rights cycle through all four combinations
        for (int i = 0; i < N; i++)
            load(20'h10 + 20'(i * 3), 6'(i % 3), 16'hA000 + 16'(i), i[0], i[1]);

        // R2 R3 R4 R5: sweep pages x tags x access x offsets
        for (int i = 0; i < N; i++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++)
                    for (int o = 0; o < 2; o++)
                        probe("R2/R3/R4 sweep",
                              {20'h10 + 20'(i * 3), (o == 0) ? 12'h000 : 12'hFED},
                              w[0], 6'(s));

        // R6: ninth load wraps to slot 0 and evicts its translation
        load(20'hBEEF0, 6'd5, 16'h7777, 1, 1);
        probe("R6 evicted slot0", {20'h10, 12'h444}, 0, 6'd0);
        probe("R6 wrapped load hit", {20'hBEEF0, 12'h123}, 1, 6'd5);

        // R9: duplicate of slot 3 placed in slot 1 -> slot 1 wins
        load(20'h10 + 20'd9, 6'd0, 16'h5151, 1, 1);
        probe("R9 lowest slot wins", {20'h10 + 20'd9, 12'h0AB}, 1, 6'd0);

        // R7: drop one page; neighbours keep theirs
        drop(20'h10 + 20'd6, 6'd2);
        probe("R7 dropped miss", {20'h10 + 20'd6, 12'h010}, 0, 6'd2);
        probe("R7 neighbour kept", {20'h10 + 20'd12, 12'h010}, 0, 6'd1);
        drop(20'h10 + 20'd9, 6'd0);
        probe("R7 both duplicates dropped", {20'h10 + 20'd9, 12'h0AB}, 1, 6'd0);

        // R10: idle opcodes leave the store
        @(negedge clk);
        upd_op = 2'd3; upd_vpn = 20'h10 + 20'd12; upd_space = 6'd1; upd_pfn = 16'h0;
        @(negedge clk);
        upd_op = 2'd0;
        @(negedge clk);
        idle_inputs();
        probe("R10 spare op no effect", {20'h10 + 20'd12, 12'h222}, 0, 6'd1);

        // R8: flush with a same-cycle load clears all, pointer unchanged
        @(negedge clk);
        flush_all = 1'b1; upd_op = 2'd1; upd_vpn = 20'h00042; upd_space = 6'd1;
        upd_pfn = 16'h4242; upd_rd = 1; upd_wr = 1;
        @(negedge clk);
        idle_inputs();
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        probe("R8 flush load ignored", {20'h00042, 12'h000}, 0, 6'd1);
        for (int i = 0; i < N; i++)
            probe("R8 flush cleared", {20'h10 + 20'(i * 3), 12'h001}, 0, 6'(i % 3));
        load(20'h00077, 6'd4, 16'h1212, 1, 0);
        probe("R8 pointer kept, R4 write fault", {20'h00077, 12'h3C0}, 1, 6'd4);
        probe("R8 pointer kept read hit", {20'h00077, 12'h3C0}, 0, 6'd4);
        for (int i = 0; i < N; i++)
            load(20'h00080 + 20'(i), 6'd7, 16'h0900 + 16'(i), 1, 1);
        probe("R6 slot after wrap", {20'h00077, 12'h3C0}, 0, 6'd4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule